// File: doc/BRIEF.md
# Prioritised Vector Interrupt Controller

This block gathers up to 32 level-sensitive interrupt request lines, masks them with a per-source enable register and raises a single interrupt output towards a processor. Sixteen programmable vector slots translate a source number into a handler address. Slot 0 is searched first and slot 15 last, so the slot index is the priority. When no slot claims an active, enabled source, a default handler address stands in.

Software reads the vector register at the start of its handler to obtain the handler address. That read also captures the vector and holds it. While the vector is held, the interrupt output stays low unless a slot of strictly higher priority becomes active. A write of any value to the vector register tells the block that the handler has finished, and the next pending request is then presented. All configuration sits behind a plain word-addressed read/write port. Reads are combinational; writes take effect on the clock edge.

Register layout (byte addresses): source enable at 0x00, vector at 0x04, default address at 0x08, slot handler address i at 0x40 + 4·i, slot control i at 0x80 + 4·i.

Top module: `vecirq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the source enable register and all slot control words read 0, and a read of the vector register returns the default address (0).
- R2: With nothing held, the interrupt output is high exactly when some request line is high and its bit in the source enable register (bit n for source n) is set; a request on a masked source leaves it low.
- R3: In a slot control word, bit 5 enables the slot and bits 4:0 name the source; a slot whose bit 5 is clear never matches.
- R4: When several enabled slots match active, enabled sources, the slot with the lowest index supplies the handler address, even if two slots name the same source.
- R5: A read of the vector register while an interrupt is presented returns the winning handler address, holds it, and drops the interrupt output from the next cycle.
- R6: While a vector is held, requests of the same or lower priority keep the interrupt output low, and reads of the vector register keep returning the held address.
- R7: While a vector is held, a matching slot of lower index than the held one raises the interrupt output, and a read then returns and holds that slot's address; any matching slot outranks a held default.
- R8: A write of any value to the vector register releases the held vector; a still-pending request is presented again in the next cycle.
- R9: When an enabled source is active but no enabled slot names it, the interrupt output is raised and the vector read returns the default address register.
- R10: The source enable, default address and slot handler registers read back the value written; slot control reads back bits 5:0 with all higher bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqIn | input | 32 | Level interrupt request per source |
| busAddr | input | 8 | Byte address of the register access |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (captures the vector on the vector register) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| irqOut | output | 1 | Interrupt request to the processor |

## Verification
Stimulus uses one masked and one unmasked source to separate the enable mask from the raw request. Two active slots with different indices show that the priority order decides the winner. Two slots that name the same source show that the lowest index wins a tie. Raising a higher-priority source while a lower one is held, and raising the lower one while a higher one is held, separate preemption from hold-off. A source with no enabled slot checks the default path. A slot that is re-enabled while a default vector is held checks that a real slot outranks the default.

// File: rtl/vecirq_pkg.sv
`timescale 1ns/1ps
package vecirq_pkg;
  // Address map: fixed byte offsets, slot regions decoded on busAddr[7:6]
  localparam int          SEL_W      = 4;   // slot index field busAddr[5:2]
  localparam int          CTL_W      = 6;   // slot control width
  localparam int          CTL_EN_BIT = 5;   // slot enable position
  localparam logic [7:0]  OFF_SRC_EN = 8'h00;
  localparam logic [7:0]  OFF_VEC    = 8'h04;
  localparam logic [7:0]  OFF_DFLT   = 8'h08;
  localparam logic [1:0]  REG_SLOT_ADDR = 2'b01;
  localparam logic [1:0]  REG_SLOT_CTL  = 2'b10;

  typedef struct packed {
    logic             wrSrcEn;
    logic             wrDflt;
    logic             wrSlotAddr;
    logic             wrSlotCtl;
    logic [SEL_W-1:0] slotSel;
    logic             latchVec;
    logic             showLive;
  } dpStrobe_t;
endpackage

// File: rtl/vecirq_search.sv
`timescale 1ns/1ps
module vecirq_search
  import vecirq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]              pendVec,
  input  logic [NUM_SLOTS-1:0][CTL_W-1:0] slotCtl,
  output logic                            slotHit,
  output logic [IDX_W-1:0]                bestIdx
);
  logic [NUM_SLOTS-1:0] hitVec;

  for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_match
    logic [SRC_W-1:0] srcNum;
    assign srcNum     = slotCtl[gi][SRC_W-1:0];
    assign hitVec[gi] = slotCtl[gi][CTL_EN_BIT] & pendVec[srcNum];
  end

  // fixed priority: lowest index wins, so scan downward and let the last hit stick
  always_comb begin
    slotHit = |hitVec;
    bestIdx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hitVec[i]) bestIdx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vecirq_datapath.sv
`timescale 1ns/1ps
module vecirq_datapath
  import vecirq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strb,
  input  logic [7:0]         busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] reqIn,
  output logic [DATA_W-1:0]  busRdata,
  output logic               anyPend,
  output logic               slotHit,
  output logic [IDX_W-1:0]   bestIdx,
  output logic [NUM_SRC-1:0] srcEnable,
  output logic [DATA_W-1:0]  vecReg
);
  logic [DATA_W-1:0]                dfltAddr;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] slotAddr;
  logic [NUM_SLOTS-1:0][CTL_W-1:0]  slotCtl;
  logic [NUM_SRC-1:0]               pendVec;
  logic [DATA_W-1:0]                liveAddr;
  logic [DATA_W-1:0]                vecView;
  logic [SEL_W-1:0]                 rdSel;

  assign pendVec = reqIn & srcEnable;
  assign anyPend = |pendVec;

  vecirq_search #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS)) u_search (
    .pendVec (pendVec),
    .slotCtl (slotCtl),
    .slotHit (slotHit),
    .bestIdx (bestIdx)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcEnable <= '0;
      dfltAddr  <= '0;
      vecReg    <= '0;
    end else begin
      if (strb.wrSrcEn)  srcEnable <= busWdata[NUM_SRC-1:0];
      if (strb.wrDflt)   dfltAddr  <= busWdata;
      if (strb.latchVec) vecReg    <= liveAddr;
    end
  end

  for (genvar gs = 0; gs < NUM_SLOTS; gs++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddr[gs] <= '0;
        slotCtl[gs]  <= '0;
      end else if (strb.slotSel == SEL_W'(gs)) begin
        if (strb.wrSlotAddr) slotAddr[gs] <= busWdata;
        if (strb.wrSlotCtl)  slotCtl[gs]  <= busWdata[CTL_W-1:0];
      end
    end
  end

  assign liveAddr = slotHit ? slotAddr[bestIdx] : dfltAddr;
  assign vecView  = strb.showLive ? liveAddr : vecReg;
  assign rdSel    = busAddr[2 +: SEL_W];

  always_comb begin
    busRdata = '0;
    if (busAddr == OFF_SRC_EN)      busRdata = DATA_W'(srcEnable);
    else if (busAddr == OFF_VEC)    busRdata = vecView;
    else if (busAddr == OFF_DFLT)   busRdata = dfltAddr;
    else if (busAddr[1:0] == 2'b00 && 32'(rdSel) < NUM_SLOTS) begin
      if (busAddr[7:6] == REG_SLOT_ADDR)
        busRdata = slotAddr[rdSel[IDX_W-1:0]];
      else if (busAddr[7:6] == REG_SLOT_CTL)
        busRdata = DATA_W'(slotCtl[rdSel[IDX_W-1:0]]);
    end
  end
endmodule

// File: rtl/vecirq_control.sv
`timescale 1ns/1ps
module vecirq_control
  import vecirq_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  localparam int IDX_W    = $clog2(NUM_SLOTS),
  localparam int PRIO_W   = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic              anyPend,
  input  logic              slotHit,
  input  logic [IDX_W-1:0]  bestIdx,
  output dpStrobe_t         strb,
  output logic              irqOut,
  output logic              latched
);
  localparam logic [PRIO_W-1:0] PRIO_DFLT = PRIO_W'(NUM_SLOTS);

  logic [PRIO_W-1:0] latchedPrio;
  logic              isVec;
  logic              alignedSlot;
  logic              higherPend;
  logic              presentable;
  logic              ackReq;
  logic              grab;

  assign isVec       = (busAddr == OFF_VEC);
  assign alignedSlot = (busAddr[1:0] == 2'b00);
  assign higherPend  = slotHit && ({1'b0, bestIdx} < latchedPrio);
  assign presentable = latched ? higherPend : anyPend;
  assign ackReq      = busWe && isVec;
  assign grab        = busRe && !busWe && isVec && presentable;
  assign irqOut      = presentable;

  always_comb begin
    strb            = '0;
    strb.wrSrcEn    = busWe && (busAddr == OFF_SRC_EN);
    strb.wrDflt     = busWe && (busAddr == OFF_DFLT);
    strb.wrSlotAddr = busWe && alignedSlot && (busAddr[7:6] == REG_SLOT_ADDR);
    strb.wrSlotCtl  = busWe && alignedSlot && (busAddr[7:6] == REG_SLOT_CTL);
    strb.slotSel    = busAddr[2 +: SEL_W];
    strb.latchVec   = grab;
    strb.showLive   = presentable || !latched;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latched     <= 1'b0;
      latchedPrio <= PRIO_DFLT;
    end else if (ackReq) begin
      latched     <= 1'b0;
      latchedPrio <= PRIO_DFLT;
    end else if (grab) begin
      latched     <= 1'b1;
      latchedPrio <= slotHit ? {1'b0, bestIdx} : PRIO_DFLT;
    end
  end
endmodule

// File: rtl/vecirq_ctrl.sv
`timescale 1ns/1ps
module vecirq_ctrl
  import vecirq_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_SLOTS = 16,
  parameter int DATA_W    = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic [7:0]         busAddr,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut
);
  localparam int IDX_W = $clog2(NUM_SLOTS);

  dpStrobe_t          strbW;
  logic               anyPendW;
  logic               slotHitW;
  logic [IDX_W-1:0]   bestIdxW;
  logic [NUM_SRC-1:0] srcEnableW;
  logic [DATA_W-1:0]  vecRegW;
  logic               latchedW;

  vecirq_control #(.NUM_SLOTS(NUM_SLOTS)) u_ctl (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .anyPend (anyPendW),
    .slotHit (slotHitW),
    .bestIdx (bestIdxW),
    .strb    (strbW),
    .irqOut  (irqOut),
    .latched (latchedW)
  );

  vecirq_datapath #(.NUM_SRC(NUM_SRC), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strbW),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .reqIn     (reqIn),
    .busRdata  (busRdata),
    .anyPend   (anyPendW),
    .slotHit   (slotHitW),
    .bestIdx   (bestIdxW),
    .srcEnable (srcEnableW),
    .vecReg    (vecRegW)
  );
endmodule

// File: rtl/vecirq_checker.sv
`timescale 1ns/1ps
module vecirq_checker
  import vecirq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] reqIn,
  input logic [NUM_SRC-1:0] srcEnable,
  input logic [7:0]         busAddr,
  input logic               busWe,
  input logic               busRe,
  input logic               irqOut,
  input logic               latched,
  input logic [DATA_W-1:0]  vecReg
);
  // R2: output only rises for an unmasked active request
  p_irq_needs_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> |(reqIn & srcEnable));

  // R5: a vector read with an unmasked request pending leaves a vector held
  p_read_holds_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && !busWe && busAddr == OFF_VEC && |(reqIn & srcEnable)) |=> latched);

  // R6: the held vector does not move without a vector register access
  p_vec_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (latched && !(busAddr == OFF_VEC && (busRe || busWe))) |=> $stable(vecReg));

  // R8: a vector register write releases the hold
  p_ack_releases_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == OFF_VEC) |=> !latched);
endmodule

bind vecirq_ctrl vecirq_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqIn     (reqIn),
  .srcEnable (srcEnableW),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busRe     (busRe),
  .irqOut    (irqOut),
  .latched   (latchedW),
  .vecReg    (vecRegW)
);

// File: tb/vecirq_ctrl_test.sv
`timescale 1ns/1ps
module vecirq_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] reqIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut;

  int vecCount = 0;
  int missCount = 0;

  localparam logic [7:0] A_EN = 8'h00, A_VEC = 8'h04, A_DF = 8'h08;

  always #2.5 clk = ~clk;

  vecirq_ctrl uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .busAddr(busAddr), .busWe(busWe),
    .busRe(busRe), .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut)
  );

  function automatic logic [7:0] slotA(input int i); return 8'h40 + 8'(4 * i); endfunction
  function automatic logic [7:0] slotC(input int i); return 8'h80 + 8'(4 * i); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic setReq(input logic [31:0] r);
    @(negedge clk);
    reqIn = r;
  endtask

  task automatic irqIs(input string req, input logic exp);
    #1 check(req, 32'(irqOut), 32'(exp));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    irqIs("R1 irq", 1'b0);
    rd(A_EN, d);     check("R1 enable", d, 32'h0);
    rd(slotC(3), d); check("R1 slot ctl", d, 32'h0);
    rd(A_VEC, d);    check("R1 vector", d, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(A_EN, 32'h0002_0040);     rd(A_EN, d);     check("R10 enable", d, 32'h0002_0040);
    wr(A_DF, 32'hDEAD_0000);     rd(A_DF, d);     check("R10 default", d, 32'hDEAD_0000);
    wr(slotA(2), 32'h1234_5678); rd(slotA(2), d); check("R10 slot addr", d, 32'h1234_5678);
    wr(slotC(2), 32'hFFFF_FFFF); rd(slotC(2), d); check("R10 slot ctl", d, 32'h0000_003F);
    wr(slotC(2), 32'h0);
  endtask

  task automatic t_mask();
    wr(slotC(1), 32'h20 | 17); wr(slotA(1), 32'h1000);
    wr(slotC(4), 32'h20 | 6);  wr(slotA(4), 32'h4000);
    wr(A_EN, 32'h0002_0000);
    setReq(32'h1 << 6);           irqIs("R2 masked source", 1'b0);
    setReq((32'h1 << 6) | (32'h1 << 17)); irqIs("R2 unmasked source", 1'b1);
    wr(A_EN, 32'h0002_0040);
  endtask

  task automatic t_priority_hold();
    logic [31:0] d;
    rd(A_VEC, d); check("R4 slot1 beats slot4", d, 32'h1000);
    irqIs("R5 irq drops when held", 1'b0);
    setReq(32'h1 << 6);
    irqIs("R6 lower held off", 1'b0);
    rd(A_VEC, d); check("R6 held address", d, 32'h1000);
    wr(A_VEC, 32'h0);
    irqIs("R8 re-presented", 1'b1);
    rd(A_VEC, d); check("R8 next vector", d, 32'h4000);
    irqIs("R5 irq low after read", 1'b0);
  endtask

  task automatic t_preempt();
    logic [31:0] d;
    setReq((32'h1 << 6) | (32'h1 << 17));
    irqIs("R7 higher raises irq", 1'b1);
    rd(A_VEC, d); check("R7 higher vector", d, 32'h1000);
    irqIs("R7 held after preempt", 1'b0);
    wr(A_VEC, 32'h5A5A_5A5A);
    irqIs("R8 any value acks", 1'b1);
    setReq(32'h0);
    irqIs("R2 idle", 1'b0);
  endtask

  task automatic t_default();
    logic [31:0] d;
    wr(slotC(1), 32'h11);
    setReq(32'h1 << 17);
    irqIs("R9 unclaimed source", 1'b1);
    rd(A_VEC, d); check("R3 R9 default used", d, 32'hDEAD_0000);
    irqIs("R9 held default", 1'b0);
    wr(slotC(1), 32'h20 | 17);
    irqIs("R7 slot over default", 1'b1);
    rd(A_VEC, d); check("R7 slot vector", d, 32'h1000);
    wr(A_VEC, 32'h0);
    setReq(32'h0);
  endtask

  task automatic t_tie();
    logic [31:0] d;
    wr(slotC(0), 32'h20 | 14);  wr(slotA(0), 32'h0E00);
    wr(slotC(15), 32'h20 | 14); wr(slotA(15), 32'hF000);
    wr(A_EN, 32'h0002_4040);
    setReq(32'h1 << 14);
    rd(A_VEC, d); check("R4 same source lowest slot", d, 32'h0E00);
    wr(A_VEC, 32'h0);
    wr(slotC(0), 32'h0E);
    rd(A_VEC, d); check("R3 disabled slot skipped", d, 32'hF000);
    wr(A_VEC, 32'h0);
    wr(A_EN, 32'h0002_0040);
    irqIs("R2 source masked again", 1'b0);
    setReq(32'h0);
  endtask

  initial begin
    #(200000 * 5);
    missCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_mask();
    t_priority_hold();
    t_preempt();
    t_default();
    t_tie();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end
endmodule